// File: doc/BRIEF.md
# Ready/Valid Register Slice

This block is one pipeline stage that sits on a ready/valid stream between a producer and a consumer. It carries one data word of parameterised width per handshake. A word moves across either side only on a rising clock edge where that side's valid and ready are both high. A packet of several words therefore moves as a series of single-word handshakes.

Both handshake outputs come straight from flip-flops. The upstream ready is not derived from the downstream ready within the cycle, and the downstream valid is not derived from the upstream valid. Stages can be chained without forming a combinational loop, and neither side waits on the other before it asserts its own signal.

Two storage entries make this possible. The first is an output entry that drives the consumer. The second is a skid entry that absorbs the one word arriving in the cycle the consumer stalls. While the consumer keeps ready high, the stage passes one word per cycle with one cycle of latency.

Top module: `rv_reg_slice`

## Requirements
- R1: A word enters only on an edge where `in_valid_i` and `in_ready_o` are both high. It leaves only on an edge where `out_valid_o` and `out_ready_i` are both high. Every accepted word leaves exactly once, with no loss, duplication or invention.
- R2: While `rst_ni` is low, and after its release until the first accepted word, `out_valid_o` is 0 and `in_ready_o` is 1. Reset clears both entries.
- R3: A word accepted into an empty stage, or into a stage whose output word leaves on the same edge, is on `out_data_o` with `out_valid_o` high in the next cycle. With `out_ready_i` held high, `in_ready_o` stays high and one word passes per cycle.
- R4: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `out_data_o` keeps its value in the next cycle.
- R5: If a word is accepted while the output word is held (`out_valid_o` high, `out_ready_i` low), that word goes into the skid entry and `in_ready_o` is low in the next cycle.
- R6: `in_ready_o` is high exactly when the skid entry is empty. When it is low, `out_valid_o` is high. An edge where `out_ready_i` is high while `in_ready_o` is low makes `in_ready_o` high in the next cycle.
- R7: Within a cycle, a change of `out_ready_i` does not change `in_ready_o`, and a change of `in_valid_i` does not change `out_valid_o`. Both change only after a clock edge.
- R8: Words leave in the order they were accepted, including the order between a word held at the output and a word waiting in the skid entry.
- R9: A word offered on `in_data_i` while `in_ready_o` is low is not taken. It never appears at the output unless it is offered again while `in_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Producer offers a word |
| in_ready_o | output | 1 | Stage can take a word (skid entry empty), registered |
| in_data_i | input | DATA_W | Word from the producer |
| out_valid_o | output | 1 | Output entry holds a word, registered |
| out_ready_i | input | 1 | Consumer takes the word on this edge |
| out_data_o | output | DATA_W | Word to the consumer, registered |

## Verification
A wrong occupancy state in this block shows up at the ports within one cycle. A stage that believes it is full when it is not drops `in_ready_o` and stalls a free-flowing stream. A stage that believes it is empty when it is not either overwrites a held word or loses the skid word. The scoreboard catches that loss or reordering when the affected word reaches the consumer. The directed stall and release sequences force the skid entry through every transition, so a misrouted load shows up as a wrong `out_data_o` one cycle after the release.

// File: rtl/rv_slice_pkg.sv
package rv_slice_pkg;

  // stage occupancy: output entry only, or output plus skid entry
  typedef enum logic [1:0] {
    OCC_EMPTY = 2'd0,
    OCC_ONE   = 2'd1,
    OCC_FULL  = 2'd2
  } occ_e;

  // source for the output entry on the next edge
  typedef enum logic [1:0] {
    LD_HOLD = 2'd0,
    LD_IN   = 2'd1,
    LD_SKID = 2'd2
  } main_sel_e;

endpackage

// File: rtl/rv_slice_ctrl.sv
module rv_slice_ctrl
  import rv_slice_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      in_valid_i,
  input  logic      out_ready_i,
  output logic      in_ready_o,
  output logic      out_valid_o,
  output main_sel_e main_sel_o,
  output logic      skid_load_o
);

  occ_e occ_q, occ_d;
  logic ready_q, valid_q;
  logic in_fire, out_fire;

  assign in_fire  = in_valid_i & ready_q;
  assign out_fire = valid_q & out_ready_i;

  always_comb begin
    occ_d       = occ_q;
    main_sel_o  = LD_HOLD;
    skid_load_o = 1'b0;
    unique case (occ_q)
      OCC_EMPTY: begin
        if (in_fire) begin
          main_sel_o = LD_IN;
          occ_d      = OCC_ONE;
        end
      end
      OCC_ONE: begin
        if (in_fire && out_fire) begin
          main_sel_o = LD_IN;
        end else if (in_fire) begin
          // consumer stalled while a word arrives: park it
          skid_load_o = 1'b1;
          occ_d       = OCC_FULL;
        end else if (out_fire) begin
          occ_d = OCC_EMPTY;
        end
      end
      OCC_FULL: begin
        if (out_fire) begin
          main_sel_o = LD_SKID;
          occ_d      = OCC_ONE;
        end
      end
      default: occ_d = OCC_EMPTY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q   <= OCC_EMPTY;
      ready_q <= 1'b1;
      valid_q <= 1'b0;
    end else begin
      occ_q   <= occ_d;
      ready_q <= (occ_d != OCC_FULL);
      valid_q <= (occ_d != OCC_EMPTY);
    end
  end

  assign in_ready_o  = ready_q;
  assign out_valid_o = valid_q;

endmodule

// File: rtl/rv_slice_store.sv
module rv_slice_store
  import rv_slice_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] in_data_i,
  input  main_sel_e         main_sel_i,
  input  logic              skid_load_i,
  output logic [DATA_W-1:0] out_data_o
);

  logic [DATA_W-1:0] main_q, skid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_q <= '0;
      skid_q <= '0;
    end else begin
      if (skid_load_i) skid_q <= in_data_i;
      unique case (main_sel_i)
        LD_IN:   main_q <= in_data_i;
        LD_SKID: main_q <= skid_q;
        default: main_q <= main_q;
      endcase
    end
  end

  assign out_data_o = main_q;

endmodule

// File: rtl/rv_reg_slice.sv
module rv_reg_slice
  import rv_slice_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o
);

  main_sel_e main_sel;
  logic      skid_load;

  rv_slice_ctrl i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .out_ready_i (out_ready_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .main_sel_o  (main_sel),
    .skid_load_o (skid_load)
  );

  rv_slice_store #(.DATA_W(DATA_W)) i_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_data_i   (in_data_i),
    .main_sel_i  (main_sel),
    .skid_load_i (skid_load),
    .out_data_o  (out_data_o)
  );

endmodule

// File: rtl/rv_reg_slice_chk.sv
module rv_reg_slice_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic [DATA_W-1:0] in_data_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DATA_W-1:0] out_data_o
);

  AST_ONE_CYCLE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && (!out_valid_o || out_ready_i)
    |=> out_valid_o && (out_data_o == $past(in_data_i)));  // R3

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));  // R4

  AST_SKID_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && out_valid_o && !out_ready_i |=> !in_ready_o);  // R5

  AST_FULL_HAS_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |-> out_valid_o);  // R6

  AST_READY_RETURNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o && out_ready_i |=> in_ready_o);  // R6

endmodule

bind rv_reg_slice rv_reg_slice_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_data_i   (in_data_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o)
);

// File: tb/test_rv_reg_slice.sv
`timescale 1ns/1ps
module test_rv_reg_slice;

  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [DW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] sb_q[$];

  always #10 clk = ~clk;

  rv_reg_slice #(.DATA_W(DW)) i_rv_reg_slice (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .in_data_i   (in_data),
    .out_valid_o (out_valid),
    .out_ready_i (out_ready),
    .out_data_o  (out_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [DW-1:0] d, input logic r);
    @(negedge clk);
    in_valid  = v;
    in_data   = d;
    out_ready = r;
  endtask

  // monitor: 1 ns before each rising edge, retire leaving word, then log entering word
  always begin
    @(negedge clk);
    #9;
    if (rst_ni) begin
      if (out_valid && out_ready) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R1 unexpected word", int'(out_data), 0);
        end else begin
          logic [DW-1:0] exp_w;
          exp_w = sb_q.pop_front();
          chk(out_data === exp_w, "R1/R8 order", int'(out_data), int'(exp_w));
        end
      end
      if (in_valid && in_ready) sb_q.push_back(in_data);
    end
  end

  initial begin
    #4_000_000;
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1 rst_ni = 1'b0;
    #5;
    chk(!out_valid && in_ready, "R2 in reset", {out_valid, in_ready}, 2'b01);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    drive(1'b0, '0, 1'b0);
    #9 chk(!out_valid && in_ready, "R2 after release", {out_valid, in_ready}, 2'b01);

    // R3: streaming with the sink always ready
    for (int i = 0; i < 8; i++) begin
      drive(1'b1, 16'hA000 + DW'(i), 1'b1);
      #9;
      chk(in_ready, "R3 ready stays high", in_ready, 1);
      if (i > 0)
        chk(out_valid && out_data == 16'hA000 + DW'(i - 1), "R3 one-cycle latency",
            out_data, 16'hA000 + i - 1);
    end
    drive(1'b0, '0, 1'b1);
    #9 chk(out_valid && out_data == 16'hA007, "R3 last word", out_data, 16'hA007);
    drive(1'b0, '0, 1'b1);
    #9 chk(!out_valid, "R1 drained", out_valid, 0);

    // R5/R4/R9/R7/R6/R8: stall with skid
    drive(1'b1, 16'hB001, 1'b0);
    drive(1'b1, 16'hB002, 1'b0);
    drive(1'b1, 16'hB003, 1'b0);
    #9;
    chk(!in_ready, "R5 ready drops after skid", in_ready, 0);
    chk(out_valid && out_data == 16'hB001, "R4 held word", out_data, 16'hB001);
    drive(1'b1, 16'hB003, 1'b0);
    #3 out_ready = 1'b1;
    #6;
    chk(!in_ready, "R7 ready ignores out_ready in cycle", in_ready, 0);
    chk(out_valid && out_data == 16'hB001, "R4 still held", out_data, 16'hB001);
    drive(1'b0, '0, 1'b0);
    #9;
    chk(in_ready, "R6 ready returns", in_ready, 1);
    chk(out_valid && out_data == 16'hB002, "R8 skid word next", out_data, 16'hB002);
    drive(1'b0, '0, 1'b1);
    drive(1'b0, '0, 1'b0);
    #9 chk(!out_valid, "R9 refused word not delivered", out_valid, 0);

    // R7: out_valid does not follow in_valid within a cycle
    drive(1'b0, '0, 1'b1);
    #3 in_valid = 1'b1; in_data = 16'hC001;
    #6 chk(!out_valid, "R7 valid ignores in_valid in cycle", out_valid, 0);
    drive(1'b0, '0, 1'b1);
    #9 chk(out_valid && out_data == 16'hC001, "R3 late offer passes", out_data, 16'hC001);

    // mixed stress
    for (int i = 0; i < 3000; i++)
      drive(1'($urandom_range(0, 1)), DW'($urandom), 1'($urandom_range(0, 3) != 0));
    for (int i = 0; i < 4; i++) drive(1'b0, '0, 1'b1);
    #9;
    chk(sb_q.size() == 0, "R1 all words delivered", sb_q.size(), 0);
    chk(!out_valid && in_ready, "R6 idle after drain", {out_valid, in_ready}, 2'b01);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule